// File: doc/BRIEF.md
# SDRAM Clock-Enable Low-Power Controller

This block owns the clock-enable (CKE) pin of an SDRAM and decides when it may be driven low. The same low level means two different things to the memory. With every bank precharged it puts the device into power-down. With a bank open or a burst in flight it freezes the device in clock suspend, where command inputs are ignored and internal state is kept. The controller takes a summary of bank state from the command sequencer, a request for low-power idle, a request to suspend, and a flag from the refresh scheduler. From these it chooses the mode, and it holds the mode for as long as the selected condition lasts.

The memory performs no refresh of its own while powered down. A refresh falling due therefore pulls the device out of power-down even when the low-power request is still asserted. Power-down is not entered again until the scheduler clears its flag. Whenever CKE returns high, the command-enable strobe stays low for a configurable wake window (one cycle by default), so that no command lands in the cycle in which the clock is re-enabled. The command sequencer must drive NOP whenever the strobe is low.

Top module: `sdram_cke_ctrl`

## Requirements
- R1: During and after synchronous reset (rst_n low), cke is 1 and cmd_en is 1, and the block is in the running mode.
- R2: In the running mode, if low_power_req=1, all_banks_idle=1 and refresh_due=0 are sampled on a clock edge, then cke and cmd_en are both 0 from that edge on (power-down).
- R3: In the running mode, if suspend_req=1 and all_banks_idle=0 are sampled on an edge and R2 does not apply, then cke and cmd_en are both 0 from that edge on (clock suspend).
- R4: A suspend_req sampled while all_banks_idle=1 and power-down is not entered has no effect: cke and cmd_en stay 1.
- R5: A low_power_req sampled while all_banks_idle=0 is held off, with cke staying 1 unless R3 applies. Power-down is entered on the edge that first samples all_banks_idle=1 while the request is still high.
- R6: Power-down lasts while low_power_req=1 and refresh_due=0, and clock suspend lasts while suspend_req=1. Changes on the other inputs during either mode do not raise cke.
- R7: When the mode's condition ends (low_power_req=0 in power-down, suspend_req=0 in suspend), cke is 1 from the next edge. cmd_en stays 0 for WAKE_CYCLES edges (default 1) after cke rises, and then returns to 1.
- R8: refresh_due=1 sampled in power-down forces an exit even while low_power_req=1, with the same timing as R7.
- R9: While refresh_due=1, power-down is not entered from the running mode. Entry resumes on the first edge that samples refresh_due=0 with the other conditions of R2 met.
- R10: cmd_en is 0 on every cycle in which cke is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| all_banks_idle | input | 1 | 1 when every bank is precharged and no burst is running |
| low_power_req | input | 1 | Level request for power-down |
| suspend_req | input | 1 | Level request for clock suspend |
| refresh_due | input | 1 | Refresh scheduler flag; held high until the refresh has completed |
| cke | output | 1 | Clock-enable pin drive, registered |
| cmd_en | output | 1 | 1 when the sequencer may issue a non-NOP command, registered |

## Verification
The assertions take the four inputs to be synchronous to clk and free of X after reset. They also take refresh_due to be a level that stays high until the refresh is done, rather than a pulse. The bench changes inputs only on the falling edge and walks every three-step sequence of the sixteen input combinations from whichever mode the previous step left. This covers each combination in the running, power-down, suspend and wake modes without breaking those assumptions. Directed runs add the held-off power-down request and the full wake window with a two-cycle setting.

// File: rtl/sdram_cke_pkg.sv
// Package: shared mode type for the CKE low-power controller.
// Assumes: nothing beyond a 2-bit encoding being sufficient.
package sdram_cke_pkg;

    typedef enum logic [1:0] {
        CKE_RUN   = 2'd0,   // clock enabled, commands allowed
        CKE_PDOWN = 2'd1,   // CKE low with all banks idle
        CKE_SUSP  = 2'd2,   // CKE low with a bank open or burst running
        CKE_WAKE  = 2'd3    // CKE high again, commands still blocked
    } cke_mode_e;

endpackage

// File: rtl/cke_entry_arb.sv
// Module: cke_entry_arb
// Decides, from the running mode, whether CKE should fall and which of the
// two low modes that means. Power-down wins over suspend, a due refresh
// blocks power-down, and suspend is only meaningful with a bank open.
// Assumes: inputs are synchronous levels sampled by the caller.
module cke_entry_arb (
    input  logic all_banks_idle,
    input  logic low_power_req,
    input  logic suspend_req,
    input  logic refresh_due,
    output logic go_pdown,
    output logic go_susp
);

    // Purpose: pick the low mode to enter, if any.
    always_comb begin
        go_pdown = low_power_req && all_banks_idle && !refresh_due;
        go_susp  = suspend_req && !all_banks_idle && !go_pdown;
    end

endmodule

// File: rtl/cke_exit_detect.sv
// Module: cke_exit_detect
// Reports when the current low mode has to end: power-down ends when its
// request drops or a refresh falls due, suspend ends when its request drops.
// Assumes: refresh_due is a level held until the refresh completes.
module cke_exit_detect
    import sdram_cke_pkg::*;
(
    input  cke_mode_e mode,
    input  logic      low_power_req,
    input  logic      suspend_req,
    input  logic      refresh_due,
    output logic      leave_low
);

    // Purpose: exit condition for whichever low mode is active.
    always_comb begin
        unique case (mode)
            CKE_PDOWN: leave_low = refresh_due || !low_power_req;
            CKE_SUSP:  leave_low = !suspend_req;
            default:   leave_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/cke_wake_timer.sv
// Module: cke_wake_timer
// Counts the cycles of the wake window after CKE rises. A start pulse
// loads the count. last is high in the final cycle of the window.
// Assumes: WAKE_CYCLES >= 1 and start is only pulsed when a window begins.
module cke_wake_timer #(
    parameter int WAKE_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);

    localparam int CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(WAKE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Purpose: flag the final cycle of the window.
    always_comb last = (cnt_q == '0);

    // R7
    wake_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == LOAD));

endmodule

// File: rtl/sdram_cke_ctrl.sv
// Module: sdram_cke_ctrl (top)
// Drives SDRAM CKE and the command-enable strobe. Chooses power-down
// (banks idle) or clock suspend (bank open) for a low CKE, leaves
// power-down by itself when a refresh falls due, and blocks commands for
// WAKE_CYCLES cycles once CKE is high again.
// Assumes: synchronous inputs; the sequencer sends NOP while cmd_en is 0.
module sdram_cke_ctrl
    import sdram_cke_pkg::*;
#(
    parameter int WAKE_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic all_banks_idle,
    input  logic low_power_req,
    input  logic suspend_req,
    input  logic refresh_due,
    output logic cke,
    output logic cmd_en
);

    cke_mode_e mode_q, mode_d;
    logic      go_pdown, go_susp, leave_low, wake_last, wake_start;
    logic      cke_q, cmd_en_q;

    cke_entry_arb u_entry (
        .all_banks_idle (all_banks_idle),
        .low_power_req  (low_power_req),
        .suspend_req    (suspend_req),
        .refresh_due    (refresh_due),
        .go_pdown       (go_pdown),
        .go_susp        (go_susp)
    );

    cke_exit_detect u_exit (
        .mode          (mode_q),
        .low_power_req (low_power_req),
        .suspend_req   (suspend_req),
        .refresh_due   (refresh_due),
        .leave_low     (leave_low)
    );

    cke_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wake_start),
        .last  (wake_last)
    );

    // Purpose: next mode from the current mode and the decisions above.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            CKE_RUN: begin
                if (go_pdown)     mode_d = CKE_PDOWN;
                else if (go_susp) mode_d = CKE_SUSP;
            end
            CKE_PDOWN, CKE_SUSP: begin
                if (leave_low)    mode_d = CKE_WAKE;
            end
            CKE_WAKE: begin
                if (wake_last)    mode_d = CKE_RUN;
            end
            default:              mode_d = CKE_RUN;
        endcase
    end

    // Purpose: start the wake window on the edge that raises CKE.
    always_comb wake_start = (mode_q != CKE_WAKE) && (mode_d == CKE_WAKE);

    // Purpose: mode register plus registered pin drives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= CKE_RUN;
            cke_q    <= 1'b1;
            cmd_en_q <= 1'b1;
        end else begin
            mode_q   <= mode_d;
            cke_q    <= (mode_d == CKE_RUN) || (mode_d == CKE_WAKE);
            cmd_en_q <= (mode_d == CKE_RUN);
        end
    end

    assign cke    = cke_q;
    assign cmd_en = cmd_en_q;

    // R10
    cke_low_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !cmd_en);

    // R7
    rise_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> !cmd_en);

    // R2
    pd_entry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CKE_PDOWN && $past(mode_q) == CKE_RUN)
            |-> ($past(all_banks_idle) && !$past(refresh_due)));

    // R3
    susp_entry_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CKE_SUSP && $past(mode_q) == CKE_RUN)
            |-> !$past(all_banks_idle));

    // R8
    pd_refresh_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CKE_PDOWN && refresh_due) |=> (cke && !cmd_en));

    // R6
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CKE_SUSP && suspend_req) |=> !cke);

endmodule

// File: tb/sdram_cke_ctrl_bench.sv
`timescale 1ns/1ps
module sdram_cke_ctrl_bench;

    localparam int W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic all_banks_idle = 1'b0;
    logic low_power_req = 1'b0;
    logic suspend_req = 1'b0;
    logic refresh_due = 1'b0;
    logic cke, cmd_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model: 0 run, 1 power-down, 2 suspend, 3 wake
    int m_mode = 0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    sdram_cke_ctrl #(.WAKE_CYCLES(W)) u_sdram_cke_ctrl (
        .clk(clk), .rst_n(rst_n), .all_banks_idle(all_banks_idle),
        .low_power_req(low_power_req), .suspend_req(suspend_req),
        .refresh_due(refresh_due), .cke(cke), .cmd_en(cmd_en)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: inputs driven at the falling edge, result checked at the next one.
    task automatic step(input logic [3:0] v);
        int    nm;
        string tag;
        low_power_req  = v[0];
        suspend_req    = v[1];
        all_banks_idle = v[2];
        refresh_due    = v[3];
        nm = m_mode;
        case (m_mode)
            0: begin
                if (v[0] && v[2] && !v[3]) begin nm = 1; tag = "R2"; end
                else if (v[1] && !v[2])    begin nm = 2; tag = "R3"; end
                else if (v[0] && v[2])     tag = "R9";
                else if (v[1])             tag = "R4";
                else                       tag = "R5";
            end
            1: begin
                if (v[3])       begin nm = 3; m_cnt = W - 1; tag = "R8"; end
                else if (!v[0]) begin nm = 3; m_cnt = W - 1; tag = "R7"; end
                else            tag = "R6";
            end
            2: begin
                if (!v[1]) begin nm = 3; m_cnt = W - 1; tag = "R7"; end
                else       tag = "R6";
            end
            default: begin
                tag = "R7";
                if (m_cnt == 0) nm = 0;
                else            m_cnt--;
            end
        endcase
        m_mode = nm;
        @(posedge clk);
        @(negedge clk);
        chk(cke, (m_mode == 0 || m_mode == 3), tag, "cke");
        chk(cmd_en, (m_mode == 0), tag, "cmd_en");
        if (cke === 1'b0) chk(cmd_en, 1'b0, "R10", "cmd_en while cke low");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cke, 1'b1, "R1", "cke in reset");
        chk(cmd_en, 1'b1, "R1", "cmd_en in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(cke, 1'b1, "R1", "cke after reset");
        chk(cmd_en, 1'b1, "R1", "cmd_en after reset");

        // R5: held-off power-down, banks open, no suspend request
        step(4'b0001);
        step(4'b0001);
        step(4'b0101);   // banks become idle: enter power-down
        chk(cke, 1'b0, "R5", "entered after idle");
        // R8: refresh due while the request stays high
        step(4'b1101);
        chk(cmd_en, 1'b0, "R8", "blocked in first wake cycle");
        step(4'b1101);
        step(4'b1101);   // wake window over, refresh still blocks entry (R9)
        chk(cmd_en, 1'b1, "R7", "commands after wake window");
        step(4'b0101);   // refresh cleared: re-enter
        chk(cke, 1'b0, "R9", "re-entry after refresh");
        step(4'b0100);
        step(4'b0100);
        step(4'b0100);

        // Sweep every three-step sequence of the 16 input combinations.
        for (int s = 0; s < 4096; s++) begin
            step(s[3:0]);
            step(s[7:4]);
            step(s[11:8]);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule